// File: doc/BRIEF.md
# Priority Interrupt Level Encoder

The block gathers thirteen interrupt request lines, numbered 1 to 13, into a pending register that follows the line levels. A mask register blocks sources one by one. Among the unmasked pending sources it picks the one with the largest 5-bit priority code taken from that source's control byte. It drives the processor with a 3-bit interrupt level and an 8-bit vector for that winner.

Software sets up the control bytes, the per-source vector bytes and the mask through a simple register port. Each byte address holds one register and the port has a combinational read. The level and vector outputs are combinational from the registered state. A register write or a change in a request line therefore shows at the outputs after the clock edge that captures it.

Top module: `irq_level_encoder`

## Requirements
- R1: The pending register takes the request lines on every clock edge after reset. Bit k of `irq_req` is source k+1. The pending register reads at address 0x3A with source n in bit n, and bit 0 reads 0.
- R2: The mask register is at address 0x36, with source n in bit n. A mask bit of 1 stops its source from winning, whatever its pending state and priority.
- R3: Source n's control byte is at address 0x14+(n-1). Its bits [4:0] are the priority code. Among active sources (pending 1, mask 0), the one with the largest code wins.
- R4: When two or more active sources share the largest code, the lowest-numbered source wins.
- R5: A source whose code is 0 never wins. When no source wins, `cpu_level` and `cpu_vector` are both 0.
- R6: `cpu_level` equals bits [4:2] of the winner's control byte.
- R7: When bit 7 of the winner's control byte is 1, `cpu_vector` equals 24 plus `cpu_level`.
- R8: When bit 7 of the winner's control byte is 0, `cpu_vector` equals source n's vector byte, located at address 0x50+(n-1).
- R9: A write to a control, vector or mask register is reflected at `cpu_level` and `cpu_vector` right after the clock edge that performs it.
- R10: Reset sets the mask to all sources blocked, so the mask reads 0x3FFE. Reset also clears the control bytes, the vector bytes and the pending register, so both outputs read 0.
- R11: A write to the pending address has no effect. Any address outside the register map reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 13 | Request lines; bit k is source k+1 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data |
| cpu_level | output | 3 | Interrupt level to the processor |
| cpu_vector | output | 8 | Interrupt vector to the processor |

## Verification
The assertions take two things for granted. Request lines and register port inputs are stable around each rising edge. Reset is held low for at least one edge before the first check. The bench changes every input only at falling edges and holds reset over several edges. The random phase writes only to mapped addresses, with arbitrary data, so that masked sources, code-0 sources and priority ties all come up at the level and vector outputs.

// File: rtl/ipe_pkg.sv
package ipe_pkg;
  localparam int ADDR_W       = 8;
  localparam int DATA_W       = 16;
  localparam int CTRL_BASE    = 'h14;
  localparam int VEC_BASE     = 'h50;
  localparam int MASK_ADDR    = 'h36;
  localparam int PEND_ADDR    = 'h3A;
  localparam int AUTOVEC_BASE = 24;

  function automatic logic [4:0] prio_code(input logic [7:0] ctrl);
    return ctrl[4:0];
  endfunction

  function automatic logic [2:0] level_of(input logic [7:0] ctrl);
    return ctrl[4:2];
  endfunction

  function automatic logic [7:0] vector_of(input logic [7:0] ctrl, input logic [7:0] vec);
    return ctrl[7] ? (8'(AUTOVEC_BASE) + {5'd0, level_of(ctrl)}) : vec;
  endfunction
endpackage

// File: rtl/ipe_regs.sv
module ipe_regs
  import ipe_pkg::*;
#(
  parameter int NSRC = 13
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NSRC-1:0]             req,
  input  logic                        wr,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wdata,
  output logic [DATA_W-1:0]           rdata,
  output logic [NSRC-1:0][7:0]        ctrl,
  output logic [NSRC-1:0][7:0]        vec,
  output logic [NSRC-1:0]             mask,
  output logic [NSRC-1:0]             pend
);
  logic mask_hit;
  assign mask_hit = wr && (int'(addr) == MASK_ADDR);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic ctrl_hit, vec_hit;
    assign ctrl_hit = wr && (int'(addr) == CTRL_BASE + g);
    assign vec_hit  = wr && (int'(addr) == VEC_BASE + g);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctrl[g] <= '0;
        vec[g]  <= '0;
      end else begin
        if (ctrl_hit) ctrl[g] <= wdata[7:0];
        if (vec_hit)  vec[g]  <= wdata[7:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask <= '1;
      pend <= '0;
    end else begin
      pend <= req;
      if (mask_hit) mask <= wdata[NSRC:1];
    end
  end

  always_comb begin
    rdata = '0;
    if (int'(addr) == MASK_ADDR) rdata[NSRC:1] = mask;
    if (int'(addr) == PEND_ADDR) rdata[NSRC:1] = pend;
    for (int k = 0; k < NSRC; k++) begin
      if (int'(addr) == CTRL_BASE + k) rdata = {8'd0, ctrl[k]};
      if (int'(addr) == VEC_BASE + k)  rdata = {8'd0, vec[k]};
    end
  end

  // R1: pending mirrors the lines one edge later
  a_r1_pending_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> pend == $past(req));
  // R11: a write to the pending address leaves the mask alone
  a_r11_pend_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(wr) && int'($past(addr)) == PEND_ADDR |-> $stable(mask));
endmodule

// File: rtl/ipe_arb.sv
module ipe_arb
  import ipe_pkg::*;
#(
  parameter int NSRC  = 13,
  parameter int IDX_W = $clog2(NSRC)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSRC-1:0]      active,
  input  logic [NSRC-1:0][7:0] ctrl,
  output logic                 win_valid,
  output logic [IDX_W-1:0]     win_idx
);
  logic [4:0] best_code;

  always_comb begin
    best_code = '0;
    win_valid = 1'b0;
    win_idx   = '0;
    for (int k = 0; k < NSRC; k++) begin
      if (active[k] && prio_code(ctrl[k]) > best_code) begin
        best_code = prio_code(ctrl[k]);
        win_valid = 1'b1;
        win_idx   = IDX_W'(k);
      end
    end
  end

  // R5: a zero code can never be the winner
  a_r5_zero_code_loses: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> prio_code(ctrl[win_idx]) != 5'd0);
  // R2: the winner is always an active source
  a_r2_winner_active: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> active[win_idx]);
endmodule

// File: rtl/irq_level_encoder.sv
module irq_level_encoder
  import ipe_pkg::*;
#(
  parameter int NSRC = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_req,
  input  logic              reg_wr,
  input  logic [7:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic [2:0]        cpu_level,
  output logic [7:0]        cpu_vector
);
  localparam int IDX_W = $clog2(NSRC);

  logic [NSRC-1:0][7:0] ctrl, vec;
  logic [NSRC-1:0]      mask, pend, active;
  logic                 win_valid;
  logic [IDX_W-1:0]     win_idx;

  ipe_regs #(.NSRC(NSRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .req(irq_req), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .ctrl(ctrl), .vec(vec),
    .mask(mask), .pend(pend)
  );

  assign active = pend & ~mask;

  ipe_arb #(.NSRC(NSRC), .IDX_W(IDX_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .active(active), .ctrl(ctrl),
    .win_valid(win_valid), .win_idx(win_idx)
  );

  always_comb begin
    cpu_level  = '0;
    cpu_vector = '0;
    if (win_valid) begin
      cpu_level  = level_of(ctrl[win_idx]);
      cpu_vector = vector_of(ctrl[win_idx], vec[win_idx]);
    end
  end

  // R5: no winner means quiet outputs
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !win_valid |-> cpu_level == 3'd0 && cpu_vector == 8'd0);
  // R2: a masked source never drives the level
  a_r2_masked_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> !mask[win_idx] && pend[win_idx]);
  // R7: autovector relation between the two outputs
  a_r7_autovector: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid && ctrl[win_idx][7] |-> cpu_vector == 8'(AUTOVEC_BASE) + {5'd0, cpu_level});
endmodule

// File: tb/tb_irq_level_encoder.sv
module tb_irq_level_encoder;
  localparam int CLK_PERIOD = 10;
  localparam int N = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] irq_req = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [2:0]  cpu_level;
  logic [7:0]  cpu_vector;

  int vectors = 0;
  int misses = 0;
  bit done = 0;

  int m_ctrl[1:N];
  int m_vec[1:N];
  int m_mask;
  int m_pend;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_level_encoder dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_level(cpu_level), .cpu_vector(cpu_vector)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // reference: scan codes from the top down, lowest source first within a code
  task automatic expect_out(output int lvl, output int vecv);
    lvl = 0; vecv = 0;
    for (int c = 31; c >= 1; c--) begin
      for (int n = 1; n <= N; n++) begin
        bit act;
        act = m_pend[n] && !m_mask[n];
        if (act && (m_ctrl[n] % 32) == c) begin
          lvl = c / 4;
          vecv = (m_ctrl[n] >= 128) ? 24 + lvl : m_vec[n];
          return;
        end
      end
    end
  endtask

  task automatic model_edge(input int req, input bit wr, input int a, input int d);
    m_pend = req * 2;
    if (wr) begin
      if (a == 'h36) m_mask = d & 'h3FFE;
      for (int n = 1; n <= N; n++) begin
        if (a == 'h13 + n) m_ctrl[n] = d & 'hFF;
        if (a == 'h4F + n) m_vec[n] = d & 'hFF;
      end
    end
  endtask

  task automatic step(input string tag, input int req, input bit wr, input int a, input int d);
    int el, ev;
    irq_req = N'(req); reg_wr = wr; reg_addr = 8'(a); reg_wdata = 16'(d);
    @(posedge clk);
    model_edge(req, wr, a, d);
    @(negedge clk);
    reg_wr = 1'b0;
    expect_out(el, ev);
    chk(tag, "cpu_level", int'(cpu_level), el);
    chk(tag, "cpu_vector", int'(cpu_vector), ev);
  endtask

  task automatic rd(input string tag, input int a, input int exp);
    reg_wr = 1'b0; reg_addr = 8'(a);
    #1;
    chk(tag, "reg_rdata", int'(reg_rdata), exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int req;
    for (int n = 1; n <= N; n++) begin m_ctrl[n] = 0; m_vec[n] = 0; end
    m_mask = 'h3FFE; m_pend = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state
    chk("R10", "cpu_level", int'(cpu_level), 0);
    chk("R10", "cpu_vector", int'(cpu_vector), 0);
    rd("R10", 'h36, 'h3FFE);
    rd("R10", 'h14, 0);
    // R2: everything masked, all lines high
    step("R2", 'h1FFF, 0, 0, 0);
    rd("R1", 'h3A, 'h3FFE);
    step("R1", 'h0A5, 0, 0, 0);
    rd("R1", 'h3A, 'h0A5 * 2);
    // R3 R6 R8: source 5 code 20, vector 0x40; others code 0 (R5)
    step("R3", 'h1FFF, 1, 'h18, 'h14);
    step("R8", 'h1FFF, 1, 'h54, 'h40);
    step("R9", 'h1FFF, 1, 'h36, 0);
    step("R6", 'h1FFF, 0, 0, 0);
    // R4: source 9 same code with autovector; source 5 still wins
    step("R4", 'h1FFF, 1, 'h1C, 'h94);
    // R7 R2: mask source 5, source 9 wins with vector 29
    step("R7", 'h1FFF, 1, 'h36, 'h0020);
    // R1 R5: drop source 9 line; only code-0 sources remain
    step("R5", 'h1FFF & ~(1 << 8), 0, 0, 0);
    // R11: pending write ignored, unmapped read zero
    step("R11", 'h00F, 1, 'h3A, 'hFFFF);
    rd("R11", 'h3A, 'h01E);
    rd("R11", 'h70, 0);
    // R3: pseudo-random traffic across the map
    for (int i = 0; i < 600; i++) begin
      int sel, a;
      req = int'($urandom_range(0, 'h1FFF));
      sel = int'($urandom_range(0, 9));
      if (sel < 4)      a = 'h14 + int'($urandom_range(0, N-1));
      else if (sel < 7) a = 'h50 + int'($urandom_range(0, N-1));
      else              a = 'h36;
      step("R3", req, ($urandom_range(0, 2) != 0), a, int'($urandom_range(0, 'hFFFF)));
    end
    finish_run();
  end
endmodule